// File: doc/BRIEF.md
# Exception stack frame sequencer

This block builds and unwinds processor exception stack frames through a memory port that moves one 16-bit word per transfer. When an exception is taken, the core hands it the vector number, the status word to save, the return address, an optional address operand, the current instruction address and a 4-bit frame format code. The sequencer aligns the stack pointer if the core does not allow unaligned data. It writes the frame one word at a time from the highest address down. It then reports the new stack pointer and the address of the vector table entry that the core must fetch.

On a return from exception, the sequencer reads the saved status word, the return address and the format word from the current stack pointer. It then moves the stack pointer past any extra words that the format calls for. A format-1 frame is a throwaway frame: the sequencer steps over it and unwinds again from the frame below. The core owns the status-register update policy and the handler fetch.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset the block is idle: mem_req_o, busy_o, done_o and format_error_o are low, and sp_o, pc_o, sr_o, fmt_o and vec_addr_o are zero.
- R2: The format word is {format code in bits 15:12, 2'b00 in bits 11:10, vector number times four in bits 9:0}.
- R3: The frame is laid out with the saved status word at the final stack pointer. Above it come the return address (high half at the lower address), then the format word, then any extra words. Writes go from the highest word address down, one word per acknowledged transfer.
- R4: Formats 2 and 3 add one 32-bit address word just above the format word. Format 4 adds the address there, with the current instruction address above it. Every other format code pushes no extra words.
- R5: With allow_unaligned_i low, bit 0 of sp_i is cleared before the frame is placed. With it high, the stack pointer is used as given.
- R6: When a push completes, sp_o is the aligned stack pointer minus twice the number of words written, and vec_addr_o is vbr_i plus four times the vector number.
- R7: A return reads words at sp, sp+2, sp+4 and sp+6. pc_o and sr_o then hold the loaded values, fmt_o holds bits 15:12 of the format word, and sp_o is sp+8 plus 0, 4, 4, 8 or 52 bytes for formats 0, 2, 3, 4 and 7.
- R8: A format-1 word on return advances the stack pointer by 8 and restarts the unwind there. The values reported are those of the last frame read.
- R9: Any format code other than 0, 1, 2, 3, 4 or 7 on return skips no extra bytes and raises format_error_o in the cycle in which done_o is high.
- R10: The request stays high with stable address, direction and write data until it is acknowledged. done_o is high for exactly one cycle, the cycle after the edge that accepts the final acknowledge, and the result outputs are valid in that cycle.
- R11: enter_i and ret_i have no effect while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enter_i | input | 1 | Start a frame push (sampled when idle) |
| ret_i | input | 1 | Start a frame unwind (sampled when idle) |
| allow_unaligned_i | input | 1 | Keep odd stack pointers as given |
| fmt_i | input | 4 | Frame format code to push |
| vec_i | input | 8 | Exception vector number |
| sr_i | input | 16 | Status word to save |
| ret_pc_i | input | 32 | Return address to save |
| cur_pc_i | input | 32 | Current instruction address (format 4) |
| fault_addr_i | input | 32 | Address operand (formats 2, 3, 4) |
| sp_i | input | 32 | Stack pointer at start |
| vbr_i | input | 32 | Vector table base |
| mem_req_o | output | 1 | Transfer request |
| mem_we_o | output | 1 | Transfer is a write |
| mem_addr_o | output | 32 | Word byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Transfer acknowledge |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| format_error_o | output | 1 | Unknown format seen on return |
| sp_o | output | 32 | Resulting stack pointer |
| pc_o | output | 32 | Return address loaded on unwind |
| vec_addr_o | output | 32 | Vector table entry address after push |
| sr_o | output | 16 | Status word loaded on unwind |
| fmt_o | output | 4 | Format code of the completed frame |

## Verification
An index counter that is off by one shows up on the first transfer: a frame word appears at the wrong address or with the wrong content, or the write count differs. A decode fault in the format handling shows as a wrong sp_o in the done cycle of that return, or as a missing or spurious format_error_o pulse. A chained unwind that fails to restart leaves pc_o and sr_o holding the values of the throwaway frame. A request that drops or changes before its acknowledge is caught on the following clock edge.

// File: rtl/efs_pkg.sv
`timescale 1ns/1ps
package efs_pkg;
  localparam int WORD_W = 16;
  localparam int FMT_W  = 4;
  localparam int IDX_W  = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP} efs_state_e;

  // extra 16-bit words pushed above the format word
  function automatic logic [IDX_W-1:0] extra_words(input logic [FMT_W-1:0] f);
    case (f)
      4'd2, 4'd3: extra_words = 3'd2;
      4'd4:       extra_words = 3'd4;
      default:    extra_words = 3'd0;
    endcase
  endfunction

  // bytes skipped past the format word on return
  function automatic logic [5:0] pop_skip(input logic [FMT_W-1:0] f);
    case (f)
      4'd2, 4'd3: pop_skip = 6'd4;
      4'd4:       pop_skip = 6'd8;
      4'd7:       pop_skip = 6'd52;
      default:    pop_skip = 6'd0;
    endcase
  endfunction

  function automatic logic fmt_known(input logic [FMT_W-1:0] f);
    case (f)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd7: fmt_known = 1'b1;
      default:                             fmt_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/efs_sp_calc.sv
`timescale 1ns/1ps
module efs_sp_calc import efs_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              allow_unaligned_i,
  input  logic [FMT_W-1:0]  fmt_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  last_idx_o
);
  logic [ADDR_W-1:0] sp_al;
  logic [IDX_W:0]    nwords;

  assign sp_al      = allow_unaligned_i ? sp_i : {sp_i[ADDR_W-1:1], 1'b0};
  assign last_idx_o = 3'd3 + extra_words(fmt_i);
  assign nwords     = {1'b0, last_idx_o} + 4'd1;
  assign base_o     = sp_al - {{(ADDR_W-IDX_W-2){1'b0}}, nwords, 1'b0};
endmodule

// File: rtl/efs_frame_builder.sv
`timescale 1ns/1ps
module efs_frame_builder import efs_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [WORD_W-1:0] sr_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD_W = WORD_W - FMT_W - VEC_W - 2;
  localparam int HI_W  = ADDR_W - WORD_W;

  logic [WORD_W-1:0] fmt_word;
  assign fmt_word = {fmt_i, {PAD_W{1'b0}}, vec_i, 2'b00};

  // index 0 sits at the final stack pointer, ascending addresses
  always_comb begin
    case (idx_i)
      3'd0:    word_o = sr_i;
      3'd1:    word_o = WORD_W'(ret_pc_i[ADDR_W-1 -: HI_W]);
      3'd2:    word_o = ret_pc_i[WORD_W-1:0];
      3'd3:    word_o = fmt_word;
      3'd4:    word_o = WORD_W'(fault_addr_i[ADDR_W-1 -: HI_W]);
      3'd5:    word_o = fault_addr_i[WORD_W-1:0];
      3'd6:    word_o = WORD_W'(cur_pc_i[ADDR_W-1 -: HI_W]);
      default: word_o = cur_pc_i[WORD_W-1:0];
    endcase
  end
endmodule

// File: rtl/efs_pop_decoder.sv
`timescale 1ns/1ps
module efs_pop_decoder import efs_pkg::*; (
  input  logic [FMT_W-1:0] fmt_i,
  output logic [5:0]       skip_o,
  output logic             chain_o,
  output logic             known_o
);
  assign skip_o  = pop_skip(fmt_i);
  assign chain_o = (fmt_i == 4'd1);
  assign known_o = fmt_known(fmt_i);
endmodule

// File: rtl/exc_frame_seq.sv
`timescale 1ns/1ps
module exc_frame_seq import efs_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enter_i,
  input  logic              ret_i,
  input  logic              allow_unaligned_i,
  input  logic [3:0]        fmt_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [15:0]       sr_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] vbr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [15:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              format_error_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [15:0]       sr_o,
  output logic [3:0]        fmt_o
);
  localparam int HI_W = ADDR_W - WORD_W;

  efs_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [FMT_W-1:0]  fmt_q;
  logic [VEC_W-1:0]  vec_q;
  logic [WORD_W-1:0] sr_q;
  logic [ADDR_W-1:0] ret_pc_q, cur_pc_q, fault_q, vbr_q;
  logic              allow_q, push_q;

  logic [ADDR_W-1:0] push_base;
  logic [IDX_W-1:0]  push_last;
  logic [WORD_W-1:0] push_word;
  logic [5:0]        pop_skip_b;
  logic              pop_chain, pop_known;

  efs_sp_calc #(.ADDR_W(ADDR_W)) u_sp_calc (
    .sp_i              (sp_i),
    .allow_unaligned_i (allow_unaligned_i),
    .fmt_i             (fmt_i),
    .base_o            (push_base),
    .last_idx_o        (push_last)
  );

  efs_frame_builder #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_builder (
    .idx_i        (idx_q),
    .fmt_i        (fmt_q),
    .vec_i        (vec_q),
    .sr_i         (sr_q),
    .ret_pc_i     (ret_pc_q),
    .cur_pc_i     (cur_pc_q),
    .fault_addr_i (fault_q),
    .word_o       (push_word)
  );

  efs_pop_decoder u_pop_dec (
    .fmt_i   (mem_rdata_i[WORD_W-1 -: FMT_W]),
    .skip_o  (pop_skip_b),
    .chain_o (pop_chain),
    .known_o (pop_known)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = busy_o;
  assign mem_we_o    = (state_q == ST_PUSH);
  assign mem_wdata_o = mem_we_o ? push_word : '0;
  assign mem_addr_o  = base_q + {{(ADDR_W-IDX_W-1){1'b0}}, idx_q, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      idx_q          <= '0;
      base_q         <= '0;
      fmt_q          <= '0;
      vec_q          <= '0;
      sr_q           <= '0;
      ret_pc_q       <= '0;
      cur_pc_q       <= '0;
      fault_q        <= '0;
      vbr_q          <= '0;
      allow_q        <= 1'b0;
      push_q         <= 1'b0;
      done_o         <= 1'b0;
      format_error_o <= 1'b0;
      sp_o           <= '0;
      pc_o           <= '0;
      vec_addr_o     <= '0;
      sr_o           <= '0;
      fmt_o          <= '0;
    end else begin
      done_o         <= 1'b0;
      format_error_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (enter_i) begin
            state_q  <= ST_PUSH;
            push_q   <= 1'b1;
            base_q   <= push_base;
            idx_q    <= push_last;
            fmt_q    <= fmt_i;
            vec_q    <= vec_i;
            sr_q     <= sr_i;
            ret_pc_q <= ret_pc_i;
            cur_pc_q <= cur_pc_i;
            fault_q  <= fault_addr_i;
            vbr_q    <= vbr_i;
            allow_q  <= allow_unaligned_i;
          end else if (ret_i) begin
            state_q <= ST_POP;
            push_q  <= 1'b0;
            base_q  <= sp_i;
            idx_q   <= '0;
          end
        end
        ST_PUSH: begin
          if (mem_ack_i) begin
            if (idx_q == '0) begin
              state_q    <= ST_IDLE;
              done_o     <= 1'b1;
              sp_o       <= base_q;
              fmt_o      <= fmt_q;
              vec_addr_o <= vbr_q + {{(ADDR_W-VEC_W-2){1'b0}}, vec_q, 2'b00};
            end else begin
              idx_q <= idx_q - 3'd1;
            end
          end
        end
        ST_POP: begin
          if (mem_ack_i) begin
            case (idx_q)
              3'd0: sr_o <= mem_rdata_i;
              3'd1: pc_o <= {mem_rdata_i[HI_W-1:0], pc_o[WORD_W-1:0]};
              3'd2: pc_o <= {pc_o[ADDR_W-1:WORD_W], mem_rdata_i};
              default: begin
                fmt_o <= mem_rdata_i[WORD_W-1 -: FMT_W];
                if (pop_chain) begin
                  base_q <= base_q + ADDR_W'(8);
                end else begin
                  state_q        <= ST_IDLE;
                  done_o         <= 1'b1;
                  format_error_o <= !pop_known;
                  sp_o <= base_q + ADDR_W'(8) + {{(ADDR_W-6){1'b0}}, pop_skip_b};
                end
              end
            endcase
            idx_q <= (idx_q == 3'd3) ? 3'd0 : idx_q + 3'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_ferr_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    format_error_o |-> done_o);

  assert_push_descending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=>
      (!mem_we_o || mem_addr_o == $past(mem_addr_o) - ADDR_W'(2)));

  assert_aligned_sp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && push_q && !allow_q) |-> !sp_o[0]);

  assert_idle_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
endmodule

// File: tb/exc_frame_seq_tb.sv
`timescale 1ns/1ps
module exc_frame_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        enter, ret, allow;
  logic [3:0]  fmt;
  logic [7:0]  vec;
  logic [15:0] sr;
  logic [31:0] rpc, cpc, fa, sp, vbr;
  logic        req, we, ack;
  logic [31:0] addr;
  logic [15:0] wdata, rdata;
  logic        busy, done, ferr;
  logic [31:0] sp_o, pc_o, va_o;
  logic [15:0] sr_o;
  logic [3:0]  fmt_o;

  exc_frame_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enter_i(enter), .ret_i(ret),
    .allow_unaligned_i(allow), .fmt_i(fmt), .vec_i(vec), .sr_i(sr),
    .ret_pc_i(rpc), .cur_pc_i(cpc), .fault_addr_i(fa), .sp_i(sp), .vbr_i(vbr),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .format_error_o(ferr), .sp_o(sp_o), .pc_o(pc_o), .vec_addr_o(va_o),
    .sr_o(sr_o), .fmt_o(fmt_o)
  );

  int nchk = 0, nerr = 0;
  int lat = 0, wcnt = 0;
  logic [15:0] mem [512];
  logic [31:0] wlog [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [31:0] a);
    return mem[a[9:1]];
  endfunction

  // memory responder: all activity on the falling edge
  initial begin
    int w;
    ack = 1'b0; rdata = '0; w = 0;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0; w = 0;
      end else if (req) begin
        if (w >= lat) begin
          if (we) begin
            mem[addr[9:1]] = wdata;
            if (wcnt < 16) wlog[wcnt] = addr;
            wcnt++;
          end else rdata = mem[addr[9:1]];
          ack = 1'b1;
        end else w++;
      end
    end
  end

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!done && n < 400);
    if (!done) chk({tag, " done timeout"}, 0, 1);
  endtask

  task automatic start_enter(input logic [3:0] f, input logic [7:0] v, input logic [31:0] s,
                             input logic al, input logic [15:0] srv, input logic [31:0] p,
                             input logic [31:0] c, input logic [31:0] a, input logic [31:0] vb);
    @(negedge clk);
    fmt = f; vec = v; sp = s; allow = al; sr = srv; rpc = p; cpc = c; fa = a; vbr = vb;
    enter = 1'b1;
    @(negedge clk);
    enter = 1'b0;
  endtask

  task automatic start_ret(input logic [31:0] s);
    @(negedge clk);
    sp = s; ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
  endtask

  task automatic put32(input logic [31:0] a, input logic [31:0] d);
    mem[a[9:1]] = d[31:16];
    mem[(a + 2) >> 1 & 511] = d[15:0];
  endtask

  typedef struct packed {
    logic [3:0]  f;
    logic [7:0]  v;
    logic [31:0] s;
    logic        al;
    logic [31:0] exp_sp;
    logic [3:0]  nw;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{4'd0, 8'h05, 32'h0000_0300, 1'b0, 32'h0000_02F8, 4'd4},
    '{4'd2, 8'h0C, 32'h0000_0301, 1'b0, 32'h0000_02F4, 4'd6},
    '{4'd3, 8'h37, 32'h0000_0280, 1'b1, 32'h0000_0274, 4'd6},
    '{4'd4, 8'h18, 32'h0000_02A1, 1'b1, 32'h0000_0291, 4'd8},
    '{4'd4, 8'hFF, 32'h0000_03FE, 1'b0, 32'h0000_03EE, 4'd8},
    '{4'd1, 8'h1A, 32'h0000_0200, 1'b0, 32'h0000_01F8, 4'd4}
  };

  initial begin
    #2_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    enter = 0; ret = 0; allow = 0; fmt = 0; vec = 0; sr = 0;
    rpc = 0; cpc = 0; fa = 0; sp = 0; vbr = 0;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req", {31'b0, req}, 0);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 done", {31'b0, done}, 0);
    chk("R1 ferr", {31'b0, ferr}, 0);
    chk("R1 sp_o", sp_o, 0);
    chk("R1 pc_o/sr_o/fmt_o", {pc_o[15:0], sr_o ^ {12'b0, fmt_o}}, 0);
    chk("R1 vec_addr_o", va_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: push, inspect memory, unwind
    for (int i = 0; i < 6; i++) begin
      vec_t t;
      logic [15:0] s16;
      logic [31:0] p, c, a, vb, top;
      t = TBL[i];
      s16 = 16'h2700 ^ 16'(i);
      p = 32'h00AB_0010 + 32'(i) * 32'h100;
      c = 32'h00CD_0000 + 32'(i);
      a = 32'hDEAD_0000 + 32'(i) * 32'h11;
      vb = 32'h0000_1000 + 32'(i) * 32'h40;
      lat = i % 3;
      wcnt = 0;
      start_enter(t.f, t.v, t.s, t.al, s16, p, c, a, vb);
      wait_done("R6 push");
      chk("R6 final sp", sp_o, t.exp_sp);
      chk("R5 alignment", {31'b0, sp_o[0]}, {31'b0, t.al & t.s[0]});
      chk("R6 vector address", va_o, vb + {22'b0, t.v, 2'b00});
      chk("R10 ferr low on push", {31'b0, ferr}, 0);
      chk("R3 word count", 32'(wcnt), 32'(t.nw));
      top = t.exp_sp + 32'(t.nw) * 2 - 2;
      chk("R3 first write highest", wlog[0], top);
      chk("R3 last write lowest", wlog[t.nw - 1], t.exp_sp);
      chk("R3 sr word", {16'b0, rd(t.exp_sp)}, {16'b0, s16});
      chk("R3 pc words", {rd(t.exp_sp + 2), rd(t.exp_sp + 4)}, p);
      chk("R2 format word", {16'b0, rd(t.exp_sp + 6)}, {16'b0, t.f, 2'b00, t.v, 2'b00});
      if (t.nw >= 6) chk("R4 address words", {rd(t.exp_sp + 8), rd(t.exp_sp + 10)}, a);
      if (t.nw == 8) chk("R4 current pc words", {rd(t.exp_sp + 12), rd(t.exp_sp + 14)}, c);
      @(posedge clk); #1;
      chk("R10 done one cycle", {31'b0, done}, 0);
      if (t.f != 4'd1) begin
        start_ret(t.exp_sp);
        wait_done("R7 unwind");
        chk("R7 sp restored", sp_o, t.al ? t.s : {t.s[31:1], 1'b0});
        chk("R7 pc loaded", pc_o, p);
        chk("R7 sr loaded", {16'b0, sr_o}, {16'b0, s16});
        chk("R7 fmt_o", {28'b0, fmt_o}, {28'b0, t.f});
        chk("R9 no error on known format", {31'b0, ferr}, 0);
      end
    end

    // R7 format 7 skips 52 bytes
    lat = 1;
    mem[9'h080] = 16'h2004;
    put32(32'h102, 32'h0012_3456);
    mem[9'h083] = 16'h7008;
    start_ret(32'h100);
    wait_done("R7 fmt7");
    chk("R7 fmt7 sp", sp_o, 32'h0000_013C);
    chk("R7 fmt7 pc", pc_o, 32'h0012_3456);
    chk("R7 fmt7 sr", {16'b0, sr_o}, 32'h2004);

    // R8 throwaway frame chains to the next one
    lat = 0;
    mem[9'h0C0] = 16'h2700;
    put32(32'h182, 32'h1111_2222);
    mem[9'h0C3] = 16'h1064;
    mem[9'h0C4] = 16'h0004;
    put32(32'h18A, 32'h3333_4444);
    mem[9'h0C7] = 16'h0010;
    start_ret(32'h180);
    wait_done("R8 chain");
    chk("R8 chain sp", sp_o, 32'h0000_0190);
    chk("R8 chain pc", pc_o, 32'h3333_4444);
    chk("R8 chain sr", {16'b0, sr_o}, 32'h0004);
    chk("R8 chain fmt", {28'b0, fmt_o}, 0);

    // R9 unknown format
    lat = 2;
    mem[9'h0E0] = 16'h2010;
    put32(32'h1C2, 32'h5555_6666);
    mem[9'h0E3] = 16'h9000;
    start_ret(32'h1C0);
    wait_done("R9 unknown");
    chk("R9 error pulse", {31'b0, ferr}, 1);
    chk("R9 no skip", sp_o, 32'h0000_01C8);
    chk("R9 pc", pc_o, 32'h5555_6666);
    @(posedge clk); #1;
    chk("R9 error one cycle", {31'b0, ferr}, 0);

    // R11 requests while busy are ignored
    begin
      int extra;
      lat = 2; wcnt = 0; extra = 0;
      start_enter(4'd0, 8'h21, 32'h340, 1'b0, 16'h2000, 32'h0000_8000, 0, 0, 32'h0);
      @(negedge clk);
      sp = 32'h3A0; fmt = 4'd4; enter = 1'b1; ret = 1'b1;
      @(negedge clk);
      enter = 1'b0; ret = 1'b0;
      wait_done("R11 busy");
      chk("R11 sp from first request", sp_o, 32'h0000_0338);
      chk("R11 vector of first request", va_o, 32'h0000_0084);
      for (int k = 0; k < 30; k++) begin
        @(posedge clk); #1;
        if (done || busy) extra++;
      end
      chk("R11 no second sequence", 32'(extra), 0);
      chk("R11 write count", 32'(wcnt), 4);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule